// File: doc/BRIEF.md
# Masked Four-Lane Integer Dot Product

This block multiplies two packed operands lane by lane and reduces the products to a single 32-bit sum. Each operand is a 128-bit word that holds four signed 32-bit integer lanes. Lane 0 occupies bits 31:0, and each higher lane sits 32 bits above the one before it. An 8-bit control word travels with the operands and carries two independent 4-bit selections.

The upper nibble decides which lane products are added into the sum. The lower nibble decides which result lanes receive that sum. Every result lane that the lower nibble does not select is written as zero. All arithmetic wraps modulo 2^32.

The unit is a two-stage pipeline with a valid/ready handshake on both sides. The first stage registers the products, and the second stage registers the placed sum. Backpressure from the output reaches the input within the same cycle. The unit accepts one input per cycle when the output is not stalled.

Top module: `dotmask4`

## Requirements
- R1: Product i equals lane i of `in_a` times lane i of `in_b`, truncated to the low 32 bits, so overflow wraps modulo 2^32.
- R2: Bit 4+i of `in_mask` set adds product i to the sum. A clear bit contributes nothing, and the sum wraps modulo 2^32.
- R3: Bit i of `in_mask` set places the sum into result lane i.
- R4: Every result lane whose bit i of `in_mask` is clear reads as zero.
- R5: Lane i occupies bits 32*i+31 down to 32*i of every 128-bit word, so lane 0 sits at the least significant end.
- R6: An input accepted at a clock edge while the output is not stalled is presented with `out_valid` high after the second following edge. It is not presented after the first.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` is low exactly when both stages hold a result and `out_ready` is low.
- R8: When `in_mask` bits 7:4 are all zero, every lane of the result is zero.
- R9: While `rst_n` is low, `out_valid` is low and `in_ready` is high. Results in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mask are offered |
| in_ready | output | 1 | Unit takes the offered operands this cycle |
| in_a | input | 128 | Operand A, four 32-bit lanes |
| in_b | input | 128 | Operand B, four 32-bit lanes |
| in_mask | input | 8 | Bits 7:4 select products, bits 3:0 select result lanes |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Placed sum, four 32-bit lanes |

## Verification
Three events can coincide at one clock edge: a new operand set is accepted, a result leaves the output register, and the first stage hands over to the second. At that edge the stall path and the forwarding path both decide the next state. Random valid and ready patterns provoke this repeatedly, including runs where the output stalls with both stages full and then releases while a new input is waiting.

A queue of reference results, computed from the mask rules, judges the outcome. Every departing word must match the head of that queue in order. `in_ready` is compared each cycle against the occupancy the queue implies.

// File: rtl/dotmask4_pkg.sv
package dotmask4_pkg;
  localparam int unsigned DM_LANES  = 4;
  localparam int unsigned DM_LANE_W = 32;
  localparam int unsigned DM_MASK_W = 2 * DM_LANES;
endpackage

// File: rtl/dm4_mul_stage.sv
module dm4_mul_stage #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned MSK_W = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [VEC_W-1:0] up_a,
  input  logic [VEC_W-1:0] up_b,
  input  logic [MSK_W-1:0] up_mask,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [VEC_W-1:0] dn_prod,
  output logic [MSK_W-1:0] dn_mask
);
  logic             v_q, v_d;
  logic             load;
  logic [VEC_W-1:0] prod_d, prod_q;
  logic [MSK_W-1:0] mask_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_mul
    logic [LANE_W-1:0] pa, pb, pp;
    assign pa = up_a[g*LANE_W +: LANE_W];
    assign pb = up_b[g*LANE_W +: LANE_W];
    assign pp = pa * pb;
    assign prod_d[g*LANE_W +: LANE_W] = pp;
  end

  assign up_ready = !v_q || dn_ready;
  assign load     = up_valid && up_ready;

  always_comb begin
    v_d = v_q;
    if (load)          v_d = 1'b1;
    else if (dn_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      prod_q <= prod_d;
      mask_q <= up_mask;
    end
  end

  assign dn_valid = v_q;
  assign dn_prod  = prod_q;
  assign dn_mask  = mask_q;

  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> v_q); // R6
  AST_STALL_KEEPS_PROD: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !dn_ready) |=> (v_q && $stable(prod_q) && $stable(mask_q))); // R7
endmodule

// File: rtl/dm4_sum_stage.sv
module dm4_sum_stage #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 32,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned MSK_W = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [VEC_W-1:0] up_prod,
  input  logic [MSK_W-1:0] up_mask,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [VEC_W-1:0] dn_data
);
  logic              v_q, v_d;
  logic              load;
  logic [LANE_W-1:0] acc;
  logic [VEC_W-1:0]  place_d, data_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      if (up_mask[LANES+i]) acc = acc + up_prod[i*LANE_W +: LANE_W];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_place
    assign place_d[g*LANE_W +: LANE_W] = up_mask[g] ? acc : '0;
  end

  assign up_ready = !v_q || dn_ready;
  assign load     = up_valid && up_ready;

  always_comb begin
    v_d = v_q;
    if (load)          v_d = 1'b1;
    else if (dn_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= place_d;
  end

  assign dn_valid = v_q;
  assign dn_data  = data_q;

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    AST_UNSEL_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load && !up_mask[g]) |-> (data_q[g*LANE_W +: LANE_W] == '0)); // R4
  end

  AST_EMPTY_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load && (up_mask[MSK_W-1:LANES] == '0)) |-> (data_q == '0)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !dn_ready) |=> (v_q && $stable(data_q))); // R7
endmodule

// File: rtl/dotmask4.sv
module dotmask4
  import dotmask4_pkg::*;
#(
  parameter int unsigned LANES  = DM_LANES,
  parameter int unsigned LANE_W = DM_LANE_W,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned MSK_W = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  input  logic [MSK_W-1:0] in_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  logic             s1_valid, s1_ready;
  logic [VEC_W-1:0] s1_prod;
  logic [MSK_W-1:0] s1_mask;

  dm4_mul_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_a     (in_a),
    .up_b     (in_b),
    .up_mask  (in_mask),
    .dn_valid (s1_valid),
    .dn_ready (s1_ready),
    .dn_prod  (s1_prod),
    .dn_mask  (s1_mask)
  );

  dm4_sum_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (s1_valid),
    .up_ready (s1_ready),
    .up_prod  (s1_prod),
    .up_mask  (s1_mask),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );

  AST_BACKPRESSURE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready && s1_valid)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && in_ready)); // R9
endmodule

// File: tb/test_dotmask4.sv
module test_dotmask4;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [127:0] in_a, in_b, out_data;
  logic [7:0]   in_mask;

  int           n_checks = 0;
  int           n_errors = 0;
  bit           done = 1'b0;
  logic [127:0] expq[$];
  string        tagq[$];
  bit           hold_pending = 1'b0;
  logic [127:0] hold_data;

  always #5 clk = ~clk;

  dotmask4 i_dotmask4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mask(in_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] model(input logic [127:0] a, b, input logic [7:0] m);
    logic [31:0]  s = '0;
    logic [31:0]  p;
    logic [127:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      p = a[i*32 +: 32] * b[i*32 +: 32];
      if (m[4+i]) s = s + p;
    end
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = m[i] ? s : 32'd0;
    return r;
  endfunction

  function automatic logic [127:0] pack4(input logic [31:0] l0, l1, l2, l3);
    return {l3, l2, l1, l0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [127:0] a, b, input logic [7:0] m,
                      input bit r, input string tag);
    bit exp_rdy;
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_mask = m; out_ready = r;
    #1;
    if (hold_pending)
      chk(out_valid && out_data == hold_data, "R7 hold", {out_valid, out_data}, {1'b1, hold_data});
    exp_rdy = (expq.size() < 2) || r;
    chk(in_ready == exp_rdy, "R7 ready", 128'(in_ready), 128'(exp_rdy));
    if (out_valid && r) begin
      if (expq.size() == 0) chk(1'b0, "R6 spurious", out_data, '0);
      else begin
        logic [127:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(out_data == e, t, out_data, e);
      end
    end
    hold_pending = out_valid && !r;
    hold_data    = out_data;
    if (v && in_ready) begin
      expq.push_back(model(a, b, m));
      tagq.push_back(tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 0; out_ready = 0; in_a = '0; in_b = '0; in_mask = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready, "R9 reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;

    // R6 latency, example mask 0x75: products 5,12,21 summed into lanes 0 and 2 (R2 R3 R4)
    step(1, pack4(1, 2, 3, 4), pack4(5, 6, 7, 8), 8'h75, 1, "R2 R3 R4 mask 0x75");
    step(0, '0, '0, 8'h00, 1, "");
    chk(!out_valid, "R6 one edge", 128'(out_valid), 0);
    step(0, '0, '0, 8'h00, 1, "");
    chk(out_valid, "R6 two edges", 128'(out_valid), 1);
    chk(out_data == pack4(38, 0, 38, 0), "R3 example", out_data, pack4(38, 0, 38, 0));

    // R5 lane 0 at bits 31:0: only lane 0 product, only lane 0 result
    step(1, pack4(7, 100, 100, 100), pack4(3, 100, 100, 100), 8'h11, 1, "R5 lane0 LSB");
    // R8 empty product selection
    step(1, pack4(9, 9, 9, 9), pack4(9, 9, 9, 9), 8'h0F, 1, "R8 zero sum");
    // R1 wrap: 0x80000001*2 = 2 mod 2^32, plus 0xFFFFFFFF*0xFFFFFFFF = 1
    step(1, pack4(32'h80000001, 32'hFFFFFFFF, 0, 0), pack4(2, 32'hFFFFFFFF, 0, 0), 8'h3F, 1, "R1 wrap");
    // R4 no destination selected
    step(1, pack4(5, 5, 5, 5), pack4(5, 5, 5, 5), 8'hF0, 1, "R4 all zero lanes");
    // R3 full broadcast, negative lanes
    step(1, pack4(-3, 4, -5, 6), pack4(2, -2, 2, 2), 8'hFF, 1, "R3 broadcast");
    repeat (4) step(0, '0, '0, 8'h00, 1, "");

    // random mix with stalls
    for (int k = 0; k < 1500; k++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, ra, rb, 8'($urandom), (k % 200 < 100) ? ($urandom % 3 != 0) : ($urandom % 4 == 0),
           "R1 R2 R3 random");
    end
    for (int k = 0; k < 10 && expq.size() != 0; k++) step(0, '0, '0, 8'h00, 1, "");
    chk(expq.size() == 0, "R6 drained", 128'(expq.size()), 0);

    // R9 reset with work in flight
    step(1, pack4(1, 1, 1, 1), pack4(1, 1, 1, 1), 8'hFF, 0, "R9");
    step(1, pack4(2, 2, 2, 2), pack4(2, 2, 2, 2), 8'hFF, 0, "R9");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R9 async reset", {out_valid, in_ready}, 2'b01);
    expq.delete(); tagq.delete(); hold_pending = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step(0, '0, '0, 8'h00, 1, "");
    chk(!out_valid, "R9 flushed", 128'(out_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule